// File: doc/BRIEF.md
# Load-Use and Branch Stall Tracker

This block keeps the cycle accounts of a pipeline model that has sixteen general registers. Every instruction is presented for one clock with a strobe. With it come up to two source operands, each with its own valid flag, an optional load destination and an optional control-transfer flag with a taken indication. The block has no effect on the pipeline itself. It only adds up the penalty cycles that the modelled pipeline would pay, and it counts how many control transfers were taken and how many were not.

A load issued by one instruction marks its destination in a pending mask. A separate instruction-complete strobe moves the pending mask into the active mask, and the active mask is what source operands are compared against. Each source operand that hits the active mask is charged on its own, so one instruction can pay twice. A taken control transfer is charged in a separate branch counter. All four counters saturate at their top value, and a synchronous clear zeroes them together with both masks.

Top module: `hazard_tally`

## Requirements
- R1: While `rst` or `clr` is high at a clock edge, all four counters become 0 and both register masks become empty, so a load recorded before the clear causes no later stall.
- R2: In a cycle with `ins_vld` high, each source operand whose valid flag is high and whose register number (bit n stands for register n) is set in the active mask adds 2 to `load_stall_cnt`. Two hitting operands add 4, even when both name the same register.
- R3: A source operand whose valid flag is low never adds to `load_stall_cnt`, whatever register number it carries.
- R4: An instruction with `ld_vld` high sets the bit of `ld_dst` in the pending mask. A source check in the same instruction uses the active mask as it was before that instruction, so a load does not stall its own instruction.
- R5: On a clock edge with `ins_end` high, the active mask is replaced by the pending mask (including a load issued in that same cycle) and the pending mask is emptied. A load therefore stalls only readers between the next and the following `ins_end`, and pending bits wait, without limit, until an `ins_end` arrives.
- R6: A valid instruction with `br_vld` and `br_taken` high adds 2 to `br_stall_cnt` and 1 to `taken_cnt`.
- R7: A valid instruction with `br_vld` high and `br_taken` low adds 1 to `untaken_cnt` and leaves `br_stall_cnt` and `taken_cnt` unchanged.
- R8: The source operands of a control-transfer instruction are checked for load stalls in the same way as those of any other instruction.
- R9: Every counter is `CNT_W` bits wide and saturates: an addition that would pass 2^CNT_W-1 leaves it at 2^CNT_W-1, and it then stays there until cleared.
- R10: In a cycle with `ins_vld` low, no counter changes and no load is recorded, whatever the other instruction fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of counters and masks |
| ins_vld | input | 1 | An instruction is presented this cycle |
| ins_end | input | 1 | Instruction boundary: pending loads become active |
| src_a_vld | input | 1 | First source operand present |
| src_a | input | IDX_W | First source register number |
| src_b_vld | input | 1 | Second source operand present |
| src_b | input | IDX_W | Second source register number |
| ld_vld | input | 1 | Instruction is a load |
| ld_dst | input | IDX_W | Load destination register number |
| br_vld | input | 1 | Instruction is a control transfer |
| br_taken | input | 1 | The control transfer is taken |
| load_stall_cnt | output | CNT_W | Accumulated load-use penalty cycles |
| br_stall_cnt | output | CNT_W | Accumulated branch penalty cycles |
| taken_cnt | output | CNT_W | Number of taken control transfers |
| untaken_cnt | output | CNT_W | Number of untaken control transfers |

## Verification
Directed sequences separate the cases that a single combined mask would get wrong: a load that is read in its own instruction, read after one boundary, and read after two boundaries. They also cover a load held pending across idle cycles, the same register named by both operands, and operands carrying a hit register with the valid flag low. Long runs of taken branches against a 6-bit counter show that the counter sticks at its top value instead of wrapping. A swept pattern then varies every instruction field, the boundary strobe and occasional clears together, and compares all four counters after every step with an arithmetic model of the masks and the saturating sums.

// File: rtl/stall_pkg.sv
package stall_pkg;

    localparam int REG_IDX_W   = 4;
    localparam int PENALTY_CYC = 2;

    typedef enum logic [1:0] {
        BR_NONE    = 2'd0,
        BR_UNTAKEN = 2'd1,
        BR_TAKEN   = 2'd2
    } br_kind_e;

    typedef struct packed {
        logic [1:0] ld_hits;
        br_kind_e   br;
    } tally_step_t;

    function automatic logic [1:0] hit_count(input logic a, input logic b);
        return {1'b0, a} + {1'b0, b};
    endfunction

endpackage

// File: rtl/ldmask_track.sv
module ldmask_track #(
    parameter int IDX_W = stall_pkg::REG_IDX_W,
    localparam int REGS = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             set_vld,
    input  logic [IDX_W-1:0] set_idx,
    input  logic             boundary,
    output logic [REGS-1:0]  active
);

    logic [REGS-1:0] pend_q;
    logic [REGS-1:0] act_q;
    logic [REGS-1:0] set_bits;
    logic [REGS-1:0] pend_next;

    always_comb begin
        set_bits  = set_vld ? (REGS'(1) << set_idx) : '0;
        pend_next = pend_q | set_bits;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pend_q <= '0;
            act_q  <= '0;
        end else if (boundary) begin
            act_q  <= pend_next;
            pend_q <= '0;
        end else begin
            pend_q <= pend_next;
        end
    end

    assign active = act_q;

endmodule

// File: rtl/src_probe.sv
module src_probe #(
    parameter int IDX_W = stall_pkg::REG_IDX_W,
    localparam int REGS = 1 << IDX_W
) (
    input  logic             en,
    input  logic             vld,
    input  logic [IDX_W-1:0] idx,
    input  logic [REGS-1:0]  active,
    output logic             hit
);

    assign hit = en & vld & active[idx];

endmodule

// File: rtl/sat_tally.sv
module sat_tally #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic [W-1:0] inc,
    output logic [W-1:0] cnt
);

    logic [W-1:0] cnt_q;
    logic [W:0]   sum;

    always_comb sum = {1'b0, cnt_q} + {1'b0, inc};

    always_ff @(posedge clk) begin
        if (rst || clr) cnt_q <= '0;
        else if (sum[W]) cnt_q <= '1;
        else cnt_q <= sum[W-1:0];
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/hazard_tally.sv
module hazard_tally
    import stall_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int IDX_W   = REG_IDX_W,
    parameter int PENALTY = PENALTY_CYC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             ins_vld,
    input  logic             ins_end,
    input  logic             src_a_vld,
    input  logic [IDX_W-1:0] src_a,
    input  logic             src_b_vld,
    input  logic [IDX_W-1:0] src_b,
    input  logic             ld_vld,
    input  logic [IDX_W-1:0] ld_dst,
    input  logic             br_vld,
    input  logic             br_taken,
    output logic [CNT_W-1:0] load_stall_cnt,
    output logic [CNT_W-1:0] br_stall_cnt,
    output logic [CNT_W-1:0] taken_cnt,
    output logic [CNT_W-1:0] untaken_cnt
);

    localparam int REGS   = 1 << IDX_W;
    localparam int NSRC   = 2;
    localparam int NCOUNT = 4;

    logic [REGS-1:0]  active;
    logic [NSRC-1:0]  src_vld;
    logic [IDX_W-1:0] src_idx [NSRC];
    logic [NSRC-1:0]  src_hit;
    tally_step_t      step;
    logic [CNT_W-1:0] incs [NCOUNT];
    logic [CNT_W-1:0] cnts [NCOUNT];

    ldmask_track #(.IDX_W(IDX_W)) u_mask (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .set_vld  (ins_vld & ld_vld),
        .set_idx  (ld_dst),
        .boundary (ins_end),
        .active   (active)
    );

    assign src_vld    = {src_b_vld, src_a_vld};
    assign src_idx[0] = src_a;
    assign src_idx[1] = src_b;

    for (genvar s = 0; s < NSRC; s++) begin : g_probe
        src_probe #(.IDX_W(IDX_W)) u_probe (
            .en     (ins_vld),
            .vld    (src_vld[s]),
            .idx    (src_idx[s]),
            .active (active),
            .hit    (src_hit[s])
        );
    end

    always_comb begin
        step.ld_hits = hit_count(src_hit[0], src_hit[1]);
        if (!(ins_vld && br_vld)) step.br = BR_NONE;
        else if (br_taken)        step.br = BR_TAKEN;
        else                      step.br = BR_UNTAKEN;
    end

    always_comb begin
        incs[0] = CNT_W'(step.ld_hits) * CNT_W'(PENALTY);
        incs[1] = (step.br == BR_TAKEN)   ? CNT_W'(PENALTY) : '0;
        incs[2] = (step.br == BR_TAKEN)   ? CNT_W'(1)       : '0;
        incs[3] = (step.br == BR_UNTAKEN) ? CNT_W'(1)       : '0;
    end

    for (genvar c = 0; c < NCOUNT; c++) begin : g_cnt
        sat_tally #(.W(CNT_W)) u_cnt (
            .clk (clk),
            .rst (rst),
            .clr (clr),
            .inc (incs[c]),
            .cnt (cnts[c])
        );
    end

    assign load_stall_cnt = cnts[0];
    assign br_stall_cnt   = cnts[1];
    assign taken_cnt      = cnts[2];
    assign untaken_cnt    = cnts[3];

endmodule

// File: rtl/hazard_tally_chk.sv
module hazard_tally_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             clr,
    input logic             ins_vld,
    input logic             src_a_vld,
    input logic             src_b_vld,
    input logic             br_vld,
    input logic             br_taken,
    input logic [CNT_W-1:0] load_stall_cnt,
    input logic [CNT_W-1:0] br_stall_cnt,
    input logic [CNT_W-1:0] taken_cnt,
    input logic [CNT_W-1:0] untaken_cnt
);

    localparam logic [CNT_W-1:0] TOP = '1;

    // R1
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (load_stall_cnt == '0 && br_stall_cnt == '0 &&
                 taken_cnt == '0 && untaken_cnt == '0));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && !ins_vld) |=> ($stable(load_stall_cnt) && $stable(br_stall_cnt) &&
                                $stable(taken_cnt) && $stable(untaken_cnt)));

    // R3
    absent_src_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && !src_a_vld && !src_b_vld) |=> $stable(load_stall_cnt));

    // R7
    untaken_only_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && ins_vld && br_vld && !br_taken) |=>
            ($stable(br_stall_cnt) && $stable(taken_cnt)));

    // R6
    taken_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && ins_vld && br_vld && br_taken && taken_cnt != TOP) |=>
            (taken_cnt - $past(taken_cnt)) == CNT_W'(1));

    // R9
    sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && load_stall_cnt == TOP) |=> load_stall_cnt == TOP);

    // R9
    br_sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && br_stall_cnt == TOP) |=> br_stall_cnt == TOP);

endmodule

bind hazard_tally hazard_tally_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/hazard_tally_bench.sv
module hazard_tally_bench;

    localparam int CW  = 6;
    localparam int IW  = 4;
    localparam int TOP = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clr = 1'b0;
    logic ins_vld = 1'b0, ins_end = 1'b0;
    logic src_a_vld = 1'b0, src_b_vld = 1'b0, ld_vld = 1'b0;
    logic br_vld = 1'b0, br_taken = 1'b0;
    logic [IW-1:0] src_a = '0, src_b = '0, ld_dst = '0;
    logic [CW-1:0] load_stall_cnt, br_stall_cnt, taken_cnt, untaken_cnt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int m_ld = 0, m_br = 0, m_tk = 0, m_un = 0;
    logic [15:0] m_act = '0, m_pend = '0;

    always #5 clk = ~clk;

    hazard_tally #(.CNT_W(CW), .IDX_W(IW)) u_hazard_tally (.*);

    function automatic int sat(input int v);
        return (v > TOP) ? TOP : v;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check(req, "load_stall_cnt", int'(load_stall_cnt), m_ld);
        check(req, "br_stall_cnt",   int'(br_stall_cnt),   m_br);
        check(req, "taken_cnt",      int'(taken_cnt),      m_tk);
        check(req, "untaken_cnt",    int'(untaken_cnt),    m_un);
    endtask

    // Called at a falling edge: drive, let one rising edge pass, update model, sample.
    task automatic step(input logic iv, input logic ie, input logic av, input int a,
                        input logic bv, input int b, input logic lv, input int ld,
                        input logic brv, input logic bt, input logic cl);
        int hits;
        logic [15:0] setb;
        ins_vld = iv; ins_end = ie; src_a_vld = av; src_a = IW'(a);
        src_b_vld = bv; src_b = IW'(b); ld_vld = lv; ld_dst = IW'(ld);
        br_vld = brv; br_taken = bt; clr = cl;
        @(posedge clk);
        if (cl) begin
            m_ld = 0; m_br = 0; m_tk = 0; m_un = 0; m_act = '0; m_pend = '0;
        end else begin
            hits = 0;
            if (iv && av && m_act[a]) hits++;
            if (iv && bv && m_act[b]) hits++;
            m_ld = sat(m_ld + 2 * hits);
            if (iv && brv && bt) begin m_br = sat(m_br + 2); m_tk = sat(m_tk + 1); end
            if (iv && brv && !bt) m_un = sat(m_un + 1);
            setb = (iv && lv) ? (16'd1 << ld) : 16'd0;
            if (ie) begin m_act = m_pend | setb; m_pend = '0; end
            else m_pend = m_pend | setb;
        end
        @(negedge clk);
        ins_vld = 1'b0; ins_end = 1'b0; clr = 1'b0;
    endtask

    // load of register r, closing the instruction
    task automatic do_load(input int r, input logic ie);
        step(1, ie, 0, 0, 0, 0, 1, r, 0, 0, 0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check_all("R1");

        // R2 and R4: load r5, next instruction reads it once
        do_load(5, 1);
        step(1, 1, 1, 5, 0, 0, 0, 0, 0, 0, 0);
        check("R2", "single hit", int'(load_stall_cnt), 2);

        // R2: both operands name the hit register
        do_load(3, 1);
        step(1, 1, 1, 3, 1, 3, 0, 0, 0, 0, 0);
        check("R2", "double hit", int'(load_stall_cnt), 6);

        // R3: operands carry hit register but are flagged absent
        do_load(9, 1);
        step(1, 1, 0, 9, 0, 9, 0, 0, 0, 0, 0);
        check("R3", "absent operands", int'(load_stall_cnt), 6);

        // R4: load and read of r4 in the same instruction, then read next
        step(1, 1, 1, 4, 0, 0, 1, 4, 0, 0, 0);
        check("R4", "own load no stall", int'(load_stall_cnt), 6);
        step(1, 1, 0, 0, 1, 4, 0, 0, 0, 0, 0);
        check("R4", "next reader stalls", int'(load_stall_cnt), 8);

        // R5: two boundaries pass before the read
        do_load(2, 1);
        step(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        step(1, 1, 1, 2, 1, 2, 0, 0, 0, 0, 0);
        check("R5", "stale load", int'(load_stall_cnt), 8);

        // R5: pending held without boundary, then a bare boundary strobe
        do_load(6, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        step(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        step(1, 1, 1, 6, 0, 0, 0, 0, 0, 0, 0);
        check("R5", "held pending", int'(load_stall_cnt), 10);

        // R8 and R6: taken branch reading a loaded register
        do_load(1, 1);
        step(1, 1, 1, 1, 0, 0, 0, 0, 1, 1, 0);
        check("R8", "branch source stall", int'(load_stall_cnt), 12);
        check("R6", "branch stall", int'(br_stall_cnt), 2);
        check("R6", "taken count", int'(taken_cnt), 1);

        // R7: untaken branch
        step(1, 1, 0, 0, 0, 0, 0, 0, 1, 0, 0);
        check("R7", "untaken count", int'(untaken_cnt), 1);
        check("R7", "branch stall kept", int'(br_stall_cnt), 2);
        check("R7", "taken kept", int'(taken_cnt), 1);

        // R10: all fields set but no instruction strobe
        do_load(7, 1);
        step(0, 0, 1, 7, 1, 7, 1, 8, 1, 1, 0);
        check_all("R10");
        step(1, 1, 1, 8, 0, 0, 0, 0, 0, 0, 0);
        check("R10", "no load recorded", int'(load_stall_cnt), 12);

        // R9: saturation of branch stall and taken counters
        for (int i = 0; i < 40; i++) step(1, 1, 0, 0, 0, 0, 0, 0, 1, 1, 0);
        check("R9", "br stall saturated", int'(br_stall_cnt), TOP);
        check("R9", "taken mid", int'(taken_cnt), 41);
        for (int i = 0; i < 30; i++) step(1, 1, 0, 0, 0, 0, 0, 0, 1, 1, 0);
        check("R9", "taken saturated", int'(taken_cnt), TOP);
        for (int i = 0; i < 30; i++) begin
            do_load(i % 16, 1);
            step(1, 1, 1, i % 16, 1, i % 16, 0, 0, 0, 0, 0);
        end
        check("R9", "load stall saturated", int'(load_stall_cnt), TOP);

        // R1: clear zeroes counters and drops an active load
        do_load(5, 1);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        check_all("R1");
        step(1, 1, 1, 5, 0, 0, 0, 0, 0, 0, 0);
        check("R1", "mask cleared", int'(load_stall_cnt), 0);

        // swept pattern against the model (R2 R3 R4 R5 R6 R7 R8 R9 R10)
        for (int i = 0; i < 1024; i++) begin
            step((i % 5) != 0, (i % 3) != 1, i[2], i % 16, i[3] ^ i[0], (i * 7) % 16,
                 i[5] | i[0], (i * 3) % 16, i[6] ^ i[1], i[7], (i % 97) == 96);
            check_all("R2");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule